// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex serial port that moves 8-bit frames without start or stop bits. It drives its own serial clock, which it derives from the system clock. Each bit goes out on `txd` and a bit comes in on `rxd` in the same serial clock period. Bits travel least-significant first. Outgoing data changes when the serial clock falls, and incoming data is sampled when it rises. Between frames the serial clock rests high.

Software reaches the port through a small register file with four addresses: control, status, transmit data and receive data. It queues a byte by writing the transmit data register and then clearing the transmit-empty flag. It collects a byte by reading the receive data register and then clearing the receive-full flag. Each flag has its own interrupt output, which gives a one-cycle pulse when the flag goes from 0 to 1.

The serial clock runs only while a frame is being transmitted, so a byte is received only while one is being sent. If a frame completes while the previous received byte has not been collected, an overrun is flagged. Both directions then stop until software clears that flag.

Top module: `sync_serial_port`

## Requirements
- R1: Register map. Address 0 is control: bit 0 enables transmit, bit 1 enables receive, bits 7:2 set the divider field. Address 1 is status: bit 0 is transmit-empty, bit 1 is receive-full, bit 2 is overrun. Address 2 is transmit data and address 3 is receive data. After reset, control reads 0x00, status reads 0x01, receive data reads 0x00, `sclk` and `txd` are 1, and both interrupts are 0.
- R2: `sclk` stays high with no edges until a byte is queued while transmit is enabled. A frame opens with a falling edge of `sclk`, and at that moment `txd` already carries the first bit.
- R3: Transmit bits leave least-significant first, and `txd` changes only in a cycle where `sclk` is low.
- R4: `rxd` is sampled on each rising edge of `sclk`, least-significant first. After the eighth bit, the byte appears at address 3, receive-full becomes 1, and `irq_rx` pulses for exactly one cycle.
- R5: When a queued byte moves into the shifter, transmit-empty returns to 1 and `irq_tx` pulses for exactly one cycle.
- R6: `sclk` stays low for divider field + 1 system clocks and high for the same count.
- R7: If the next byte is queued before the current frame ends, the next frame starts one half period after the last rising edge. This leaves no idle gap between frames.
- R8: If nothing is queued when a frame ends, `sclk` stays high and `txd` keeps the last bit sent.
- R9: A frame that completes while receive-full is 1 sets overrun and leaves the receive data unchanged. While overrun is 1, no frame starts, even when a byte is queued.
- R10: Writing control with both enables 0 in the middle of a frame returns `sclk` to high within one cycle, and no further edges follow.
- R11: Clearing only the transmit enable lets the current frame finish. A byte queued after that frame does not start.
- R12: With receive disabled, frames still transmit, but receive-full and the receive data register do not change.
- R13: A status write clears each flag whose bit is written as 0. A flag whose bit is written as 1 is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for the current `addr` |
| rxd | input | 1 | Serial receive data |
| sclk | output | 1 | Generated serial clock, high when idle |
| txd | output | 1 | Serial transmit data |
| irq_tx | output | 1 | One-cycle pulse when transmit-empty rises |
| irq_rx | output | 1 | One-cycle pulse when receive-full rises |

## Verification
The bench acts as the serial partner. It captures `txd` on every rising edge of `sclk` and presents `rxd` on every falling edge, and it timestamps the edges.

The corner cases it targets are these:
- **Stale clock:** a design that lets the clock toggle before the first byte is queued shows falls in the bench's count.
- **Frame gap:** a design that adds an idle gap between queued frames lengthens the measured interval between frames.
- **Overrun:** a design that keeps shifting during an overrun starts the queued frame too early. A design that overwrites the receive data on overrun returns the wrong byte.
- **Abort and disable:** the bench stops the port in mid-frame by clearing both enables, and in a separate test by clearing the transmit enable alone. A design that ignores either keeps producing clock edges.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_TXD  = 2'd2;
  localparam logic [1:0] A_RXD  = 2'd3;

  localparam int S_TXE = 0;
  localparam int S_RXF = 1;
  localparam int S_OVR = 2;

  // A half period ends once the counter has reached the programmed field
  function automatic logic half_elapsed(input int unsigned cnt, input int unsigned field);
    return cnt == field;
  endfunction

  // Number of system clocks in one half period for a given field
  function automatic int unsigned half_cycles(input int unsigned field);
    return field + 1;
  endfunction
endpackage

// File: rtl/ssp_clkgen.sv
`timescale 1ns/1ps
module ssp_clkgen import ssp_pkg::*; #(
  parameter int DIV_W = 6,
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             go,
  input  logic             abort,
  output logic             sclk,
  output logic             load,
  output logic             rise,
  output logic             shift,
  output logic             done
);
  localparam int BCW = $clog2(NBITS + 1);

  logic             active, sclk_q;
  logic [DIV_W-1:0] cnt;
  logic [BCW-1:0]   nrise;
  logic             tick, boundary;

  assign tick     = active && half_elapsed(32'(cnt), 32'(half_div));
  assign rise     = tick && !sclk_q;
  assign boundary = tick && sclk_q && (nrise == BCW'(NBITS));
  assign shift    = tick && sclk_q && (nrise != BCW'(NBITS));
  assign load     = !abort && go && (!active || boundary);
  assign done     = rise && (nrise == BCW'(NBITS - 1));
  assign sclk     = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0; sclk_q <= 1'b1; cnt <= '0; nrise <= '0;
    end else if (abort) begin
      active <= 1'b0; sclk_q <= 1'b1; cnt <= '0; nrise <= '0;
    end else if (load) begin
      active <= 1'b1; sclk_q <= 1'b0; cnt <= '0; nrise <= '0;
    end else if (boundary) begin
      active <= 1'b0; cnt <= '0;
    end else if (tick) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
      if (rise) nrise <= nrise + BCW'(1);
    end else if (active) begin
      cnt <= cnt + DIV_W'(1);
    end
  end

  assert_abort_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (sclk_q && !active));
  assert_start_falls_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !active) |=> !sclk_q);
  assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !load) |=> sclk_q);
endmodule

// File: rtl/ssp_shift.sv
`timescale 1ns/1ps
module ssp_shift #(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             shift,
  input  logic             rise,
  input  logic [NBITS-1:0] tx_word,
  input  logic             rxd,
  output logic             txd,
  output logic [NBITS-1:0] rx_word
);
  logic [NBITS-2:0] tx_sh;
  logic [NBITS-1:0] rx_sh;
  logic             txd_q;

  assign txd     = txd_q;
  // Word as it stands once the current rising-edge bit is included
  assign rx_word = {rxd, rx_sh[NBITS-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q <= 1'b1; tx_sh <= '0;
    end else if (load) begin
      txd_q <= tx_word[0];
      tx_sh <= tx_word[NBITS-1:1];
    end else if (shift) begin
      txd_q <= tx_sh[0];
      tx_sh <= {1'b0, tx_sh[NBITS-2:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_sh <= '0;
    else if (rise) rx_sh <= rx_word;
  end
endmodule

// File: rtl/ssp_regs.sv
`timescale 1ns/1ps
module ssp_regs import ssp_pkg::*; #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          load,
  input  logic          done,
  input  logic [DW-1:0] rx_word,
  output logic [DW-1:0] tx_word,
  output logic [DW-3:0] half_div,
  output logic          go,
  output logic          abort,
  output logic          irq_tx,
  output logic          irq_rx
);
  logic          tx_en, rx_en, txe, rxf, ovr, txe_d, rxf_d;
  logic [DW-3:0] div_q;
  logic [DW-1:0] tx_q, rx_q;
  logic          wr_ctrl, wr_stat, wr_txd, store, ovr_hit;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign wr_txd  = wr_en && (addr == A_TXD);
  assign store   = done && rx_en && !rxf;
  assign ovr_hit = done && rx_en && rxf;

  assign go       = tx_en && !txe && !ovr;
  assign abort    = !tx_en && !rx_en;
  assign tx_word  = tx_q;
  assign half_div = div_q;
  assign irq_tx   = txe && !txe_d;
  assign irq_rx   = rxf && !rxf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en <= 1'b0; rx_en <= 1'b0; div_q <= '0; tx_q <= '0;
    end else begin
      if (wr_ctrl) begin
        tx_en <= wr_data[0];
        rx_en <= wr_data[1];
        div_q <= wr_data[DW-1:2];
      end
      if (wr_txd) tx_q <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe <= 1'b1; rxf <= 1'b0; ovr <= 1'b0; rx_q <= '0;
      txe_d <= 1'b1; rxf_d <= 1'b0;
    end else begin
      txe_d <= txe;
      rxf_d <= rxf;
      if (load) txe <= 1'b1;
      else if (wr_stat && !wr_data[S_TXE]) txe <= 1'b0;
      if (store) rxf <= 1'b1;
      else if (wr_stat && !wr_data[S_RXF]) rxf <= 1'b0;
      if (ovr_hit) ovr <= 1'b1;
      else if (wr_stat && !wr_data[S_OVR]) ovr <= 1'b0;
      if (store) rx_q <= rx_word;
    end
  end

  always_comb begin
    case (addr)
      A_CTRL:  rd_data = {div_q, rx_en, tx_en};
      A_STAT:  rd_data = {{(DW-3){1'b0}}, ovr, rxf, txe};
      A_TXD:   rd_data = tx_q;
      default: rd_data = rx_q;
    endcase
  end

  assert_ovr_blocks_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> !load);
  assert_rx_kept_on_ovr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rxf) |=> $stable(rx_q));
  assert_load_sets_txe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> txe);
  assert_irq_rx_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx |=> !irq_rx);
endmodule

// File: rtl/sync_serial_port.sv
`timescale 1ns/1ps
module sync_serial_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          rxd,
  output logic          sclk,
  output logic          txd,
  output logic          irq_tx,
  output logic          irq_rx
);
  localparam int DIV_W = DW - 2;

  logic [DIV_W-1:0] half_div;
  logic [DW-1:0]    tx_word, rx_word;
  logic             go, abort, load, rise, shift, done;

  ssp_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .load(load), .done(done), .rx_word(rx_word),
    .tx_word(tx_word), .half_div(half_div), .go(go), .abort(abort),
    .irq_tx(irq_tx), .irq_rx(irq_rx));

  ssp_clkgen #(.DIV_W(DIV_W), .NBITS(DW)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .go(go), .abort(abort),
    .sclk(sclk), .load(load), .rise(rise), .shift(shift), .done(done));

  ssp_shift #(.NBITS(DW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift), .rise(rise),
    .tx_word(tx_word), .rxd(rxd), .txd(txd), .rx_word(rx_word));

  assert_txd_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> !sclk);
endmodule

// File: tb/sync_serial_port_bench.sv
`timescale 1ns/1ps
module sync_serial_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b1, wr_en = 1'b0, rxd = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'd0, rd_data;
  logic       sclk, txd, irq_tx, irq_rx;

  int n_checks = 0, n_err = 0;
  int ser_bit = 0, fcount = 0, nfalls = 0, n_itx = 0, n_irx = 0;
  logic [7:0] rx_src [8];
  logic [7:0] tx_log [8];
  logic [7:0] tx_cap;
  time fstart [8];
  time fend [8];
  time t_rise0, t_fall1;

  sync_serial_port u_sync_serial_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .rxd(rxd), .sclk(sclk), .txd(txd),
    .irq_tx(irq_tx), .irq_rx(irq_rx));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Serial partner: drive rxd on falling sclk, capture txd on rising sclk
  initial forever begin
    @(negedge sclk);
    if (ser_bit == 0) fstart[fcount % 8] = $time;
    if (ser_bit == 1) t_fall1 = $time;
    rxd = rx_src[fcount % 8][ser_bit];
    nfalls++;
  end

  initial forever begin
    @(posedge sclk);
    if (ser_bit == 0) t_rise0 = $time;
    tx_cap[ser_bit % 8] = txd;
    if (ser_bit >= 7) begin
      fend[fcount % 8] = $time;
      tx_log[fcount % 8] = tx_cap;
      fcount++;
      ser_bit = 0;
    end else ser_bit++;
  end

  initial forever begin
    @(negedge clk);
    if (irq_tx) n_itx++;
    if (irq_rx) n_irx++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic [7:0] st;
    for (int i = 0; i < 2000; i++) begin
      host_rd(2'd1, st);
      if (st[0]) break;
    end
    host_wr(2'd2, b);
    host_wr(2'd1, 8'h06);
  endtask

  task automatic wait_frames(input int target);
    for (int g = 0; g < 20000 && fcount < target; g++) @(negedge clk);
    idle(3);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rst_n = 1'b0; idle(3); rst_n = 1'b1;
    ser_bit = 0; fcount = 0; nfalls = 0; n_itx = 0; n_irx = 0;
    idle(2);
    host_rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    host_rd(2'd1, v); chk("R1 status", v, 8'h01);
    host_rd(2'd3, v); chk("R1 rxdata", v, 8'h00);
    chk("R1 sclk", sclk, 1); chk("R1 txd", txd, 1);
    chk("R1 irqs", {irq_tx, irq_rx}, 0);
  endtask

  task automatic t_first_frame;
    logic [7:0] v;
    host_wr(2'd0, 8'h07);
    idle(20);
    chk("R2 no clock before queue", nfalls, 0);
    rx_src[0] = 8'h3C;
    n_itx = 0; n_irx = 0;
    send_byte(8'h35);
    wait_frames(1);
    chk("R3 tx bits lsb first", tx_log[0], 8'h35);
    chk("R2 clock started", nfalls, 8);
    chk("R6 low half", int'((t_rise0 - fstart[0]) / CLK_PERIOD), 2);
    chk("R6 high half", int'((t_fall1 - t_rise0) / CLK_PERIOD), 2);
    host_rd(2'd3, v); chk("R4 rx byte", v, 8'h3C);
    host_rd(2'd1, v); chk("R4 R5 status", v, 8'h03);
    chk("R4 irq_rx one pulse", n_irx, 1);
    chk("R5 irq_tx one pulse", n_itx, 1);
    idle(10);
    chk("R8 sclk idle high", sclk, 1);
    chk("R8 txd holds bit7", txd, 0);
    chk("R8 no extra edges", nfalls, 8);
  endtask

  task automatic t_back_to_back;
    logic [7:0] v;
    int base;
    host_wr(2'd1, 8'h05);
    host_wr(2'd0, 8'h09);
    base = fcount;
    send_byte(8'h5A);
    send_byte(8'hC3);
    wait_frames(base + 2);
    chk("R7 frame a", tx_log[base % 8], 8'h5A);
    chk("R7 frame b", tx_log[(base + 1) % 8], 8'hC3);
    chk("R7 no gap", int'((fstart[(base + 1) % 8] - fend[base % 8]) / CLK_PERIOD), 3);
    host_rd(2'd1, v); chk("R12 rx_full unchanged", v, 8'h01);
    host_rd(2'd3, v); chk("R12 rxdata unchanged", v, 8'h3C);
  endtask

  task automatic t_overrun;
    logic [7:0] v;
    int base, nf;
    host_wr(2'd0, 8'h07);
    base = fcount;
    rx_src[base % 8] = 8'h11;
    rx_src[(base + 1) % 8] = 8'h22;
    rx_src[(base + 2) % 8] = 8'h33;
    send_byte(8'hA1);
    send_byte(8'hA2);
    wait_frames(base + 2);
    host_rd(2'd1, v); chk("R9 overrun set", v, 8'h07);
    host_rd(2'd3, v); chk("R9 rxdata kept", v, 8'h11);
    send_byte(8'h99);
    nf = nfalls;
    idle(40);
    chk("R9 frozen", nfalls - nf, 0);
    host_wr(2'd1, 8'h01);
    wait_frames(base + 3);
    chk("R9 resumes tx", tx_log[(base + 2) % 8], 8'h99);
    host_rd(2'd3, v); chk("R9 resumes rx", v, 8'h33);
  endtask

  task automatic t_abort;
    int nf, base;
    host_wr(2'd0, 8'h1F);
    base = fcount;
    send_byte(8'hF0);
    for (int g = 0; g < 2000 && ser_bit < 3; g++) @(negedge clk);
    host_wr(2'd0, 8'h1C);
    chk("R10 sclk high at once", sclk, 1);
    nf = nfalls;
    idle(50);
    chk("R10 no edges after abort", nfalls - nf, 0);
    chk("R10 frame not completed", fcount, base);
    ser_bit = 0;
  endtask

  task automatic t_tx_disable;
    logic [7:0] v;
    int base, nf;
    host_wr(2'd0, 8'h17);
    host_wr(2'd1, 8'h05);
    base = fcount;
    rx_src[base % 8] = 8'h44;
    send_byte(8'h81);
    send_byte(8'h7E);
    host_wr(2'd0, 8'h16);
    wait_frames(base + 1);
    chk("R11 current frame finished", tx_log[base % 8], 8'h81);
    nf = nfalls;
    idle(80);
    chk("R11 queued byte held", nfalls - nf, 0);
    host_rd(2'd1, v); chk("R11 status", v, 8'h02);
    host_rd(2'd3, v); chk("R4 rx with tx off later", v, 8'h44);
    host_wr(2'd1, 8'h07);
    host_rd(2'd1, v); chk("R13 write ones no effect", v, 8'h02);
    host_wr(2'd1, 8'h05);
    host_rd(2'd1, v); chk("R13 write zero clears", v, 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rx_src[i] = 8'h00;
    #1;
    t_reset();
    t_first_frame();
    t_back_to_back();
    t_overrun();
    t_abort();
    t_tx_disable();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule